// File: doc/BRIEF.md
# Multi-Lane Serial Transaction Sequencer

This block runs one serial transfer whose byte count is set before it starts. It moves bytes over one, two or four data lines. A mode code picks the line count. Each byte goes out most significant bit first. A separate clock generator supplies a beat strobe, and each beat moves one line-group of bits. The sequencer tells the generator when to run the serial clock through `sclk_en_o`. The generator drops that clock while the sequencer waits at a byte boundary.

Transmit bytes come from an external transmit FIFO through a pop handshake. Received bytes go to an external receive FIFO through a push handshake. Transmit and receive can each be switched on alone or together. When the final byte completes, a sticky done flag rises and stays up until a clear pulse. A soft reset stops a transfer at any point and returns the block to idle.

Top module: `mlx_xfer_seq`

## Requirements
- R1: A rising edge on `en_i` while idle starts a transfer, and `busy_o` is high from the next cycle. The length, mode and direction enables are captured at that edge, so later changes to those inputs do not affect the running transfer.
- R2: The mode code sets the lane use:
  - Code 0 uses 8 beats per byte. It sends on `dq_o[0]` and samples `dq_i[1]`.
  - Code 1 uses 4 beats per byte. It uses lanes [1:0], with the earlier bit on lane 1.
  - Code 2 uses 2 beats per byte. It uses lanes [3:0], with the earlier bit on lane 3.
  - Codes 3 to 7 behave as code 0.
  - In every mode the most significant bit goes first, and unused output lanes stay 0.
- R3: With transmit on, if the transmit FIFO is empty at a byte boundary, the beat clock stays stopped (`sclk_en_o` low, no pop) until data is present.
- R4: With receive on, if the receive FIFO is full at a byte boundary, the beat clock stays stopped until the FIFO has space.
- R5: With transmit off, `dq_o` is all zero for the whole transfer, no pop is issued, and an empty transmit FIFO causes no stall.
- R6: With receive off, no push is issued. With receive on, each byte is pushed in the cycle of its final beat, and `rx_data_o` carries the sampled bits.
- R7: `done_o` rises in the cycle after the final beat of the last byte. It stays high until a `done_clr_i` pulse, which clears it in the next cycle.
- R8: A `srst_i` pulse aborts a running transfer. In the next cycle `busy_o`, `sclk_en_o`, `done_o` and `dq_o` are all 0, and no further pops follow.
- R9: A start with a length of 0 sets `done_o` in the next cycle with no beat, pop or push.
- R10: Holding `en_i` high after completion does not start a new transfer, and an `en_i` edge during a busy transfer is ignored.
- R11: A transfer of length N pops exactly N bytes (transmit on) and pushes exactly N bytes (receive on), for any N up to 2^LEN_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Start request; a rising edge starts a transfer |
| srst_i | input | 1 | Soft reset; aborts and returns to idle |
| mode_i | input | 3 | Lane mode code (0 one line, 1 two, 2 four) |
| tx_en_i | input | 1 | Consume transmit data |
| rx_en_i | input | 1 | Produce receive data |
| len_i | input | LEN_W | Byte count of the transfer |
| done_clr_i | input | 1 | Clears the done flag |
| beat_i | input | 1 | Beat strobe from the clock generator |
| sclk_en_o | output | 1 | Serial clock run request |
| dq_o | output | 4 | Outgoing data lines |
| dq_i | input | 4 | Incoming data lines |
| tx_data_i | input | 8 | Head byte of the transmit FIFO |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_pop_o | output | 1 | Take the head byte of the transmit FIFO |
| rx_data_o | output | 8 | Received byte |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Write `rx_data_o` into the receive FIFO |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
The hardest conditions to reach from the ports are the stalls at a byte boundary. They need the engine to be mid-transfer with the neighbouring FIFO in just the wrong state. The bench models both FIFOs itself. It starts a transfer with the transmit queue deliberately empty, or with the receive full flag forced high. It then watches several idle cycles before it supplies data or frees space. The soft-reset abort also needs the engine caught mid-byte, so the bench counts beats and raises the reset partway through a multi-byte transfer.

// File: rtl/mlx_pkg.sv
package mlx_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int BEAT_W = $clog2(BYTE_W) + 1;

    typedef enum logic [1:0] {
        LANE_X1,
        LANE_X2,
        LANE_X4
    } lane_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BOUND,
        ST_SHIFT
    } seq_st_e;

    typedef struct packed {
        lane_e lanes;
        logic  tx_on;
        logic  rx_on;
    } xfer_cfg_t;

    function automatic lane_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return LANE_X2;
            3'd2:    return LANE_X4;
            default: return LANE_X1;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] beats_for(input lane_e l);
        case (l)
            LANE_X2: return BEAT_W'(BYTE_W / 2);
            LANE_X4: return BEAT_W'(BYTE_W / 4);
            default: return BEAT_W'(BYTE_W);
        endcase
    endfunction

endpackage

// File: rtl/mlx_seq_ctrl.sv
module mlx_seq_ctrl
    import mlx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srst_i,
    input  logic             en_i,
    input  logic [2:0]       mode_i,
    input  logic             tx_en_i,
    input  logic             rx_en_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             done_clr_i,
    input  logic             beat_i,
    input  logic             tx_empty_i,
    input  logic             rx_full_i,
    output xfer_cfg_t        cfg_o,
    output logic             load_o,
    output logic             fire_o,
    output logic             byte_end_o,
    output logic             busy_o,
    output logic             shifting_o,
    output logic             done_o
);

    seq_st_e           st_q;
    xfer_cfg_t         cfg_q;
    logic [LEN_W-1:0]  remain_q;
    logic [BEAT_W-1:0] beat_left_q;
    logic              en_q;
    logic              done_q;
    logic              start;
    logic              set_done;

    assign start      = (st_q == ST_IDLE) && en_i && !en_q;
    assign load_o     = (st_q == ST_BOUND)
                        && (!cfg_q.tx_on || !tx_empty_i)
                        && (!cfg_q.rx_on || !rx_full_i);
    assign fire_o     = (st_q == ST_SHIFT) && beat_i;
    assign byte_end_o = fire_o && (beat_left_q == BEAT_W'(1));
    assign set_done   = (start && (len_i == '0))
                        || (byte_end_o && (remain_q == LEN_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_i;
    end

    always_ff @(posedge clk) begin
        if (rst || srst_i) begin
            st_q        <= ST_IDLE;
            cfg_q       <= '{lanes: LANE_X1, tx_on: 1'b0, rx_on: 1'b0};
            remain_q    <= '0;
            beat_left_q <= '0;
            done_q      <= 1'b0;
        end else begin
            if (set_done)        done_q <= 1'b1;
            else if (done_clr_i) done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    cfg_q    <= '{lanes: decode_mode(mode_i), tx_on: tx_en_i, rx_on: rx_en_i};
                    remain_q <= len_i;
                    if (len_i != '0) st_q <= ST_BOUND;
                end
                ST_BOUND: if (load_o) begin
                    beat_left_q <= beats_for(cfg_q.lanes);
                    st_q        <= ST_SHIFT;
                end
                ST_SHIFT: if (fire_o) begin
                    beat_left_q <= beat_left_q - BEAT_W'(1);
                    if (byte_end_o) begin
                        remain_q <= remain_q - LEN_W'(1);
                        st_q     <= (remain_q == LEN_W'(1)) ? ST_IDLE : ST_BOUND;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg_o      = cfg_q;
    assign busy_o     = (st_q != ST_IDLE);
    assign shifting_o = (st_q == ST_SHIFT);
    assign done_o     = done_q;

    // R3
    tx_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BOUND && cfg_q.tx_on && tx_empty_i) |=> (st_q != ST_SHIFT));

    // R4
    rx_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BOUND && cfg_q.rx_on && rx_full_i) |=> (st_q != ST_SHIFT));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !done_clr_i && !srst_i) |=> done_o);

    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        srst_i |=> (!busy_o && !done_o));

endmodule

// File: rtl/mlx_lane_shifter.sv
module mlx_lane_shifter
    import mlx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst_i,
    input  lane_e             lanes_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              fire_i,
    input  logic [LANES-1:0]  dq_i,
    output logic [LANES-1:0]  dq_o,
    output logic [BYTE_W-1:0] rx_nxt_o
);

    logic [BYTE_W-1:0] tsr_q;
    logic [BYTE_W-1:0] rsr_q;
    logic [BYTE_W-1:0] tsr_nxt;

    always_comb begin
        case (lanes_i)
            LANE_X2: begin
                tsr_nxt  = {tsr_q[BYTE_W-3:0], 2'b00};
                rx_nxt_o = {rsr_q[BYTE_W-3:0], dq_i[1:0]};
                dq_o     = {2'b00, tsr_q[BYTE_W-1 -: 2]};
            end
            LANE_X4: begin
                tsr_nxt  = {tsr_q[BYTE_W-5:0], 4'b0000};
                rx_nxt_o = {rsr_q[BYTE_W-5:0], dq_i};
                dq_o     = tsr_q[BYTE_W-1 -: 4];
            end
            default: begin
                tsr_nxt  = {tsr_q[BYTE_W-2:0], 1'b0};
                rx_nxt_o = {rsr_q[BYTE_W-2:0], dq_i[1]};
                dq_o     = {3'b000, tsr_q[BYTE_W-1]};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || srst_i) begin
            tsr_q <= '0;
            rsr_q <= '0;
        end else begin
            if (load_i)      tsr_q <= load_val_i;
            else if (fire_i) tsr_q <= tsr_nxt;
            if (fire_i)      rsr_q <= rx_nxt_o;
        end
    end

endmodule

// File: rtl/mlx_xfer_seq.sv
module mlx_xfer_seq
    import mlx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             srst_i,
    input  logic [2:0]       mode_i,
    input  logic             tx_en_i,
    input  logic             rx_en_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             done_clr_i,
    input  logic             beat_i,
    output logic             sclk_en_o,
    output logic [3:0]       dq_o,
    input  logic [3:0]       dq_i,
    input  logic [7:0]       tx_data_i,
    input  logic             tx_empty_i,
    output logic             tx_pop_o,
    output logic [7:0]       rx_data_o,
    input  logic             rx_full_i,
    output logic             rx_push_o,
    output logic             busy_o,
    output logic             done_o
);

    xfer_cfg_t cfg;
    logic      load;
    logic      fire;
    logic      byte_end;

    mlx_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .srst_i     (srst_i),
        .en_i       (en_i),
        .mode_i     (mode_i),
        .tx_en_i    (tx_en_i),
        .rx_en_i    (rx_en_i),
        .len_i      (len_i),
        .done_clr_i (done_clr_i),
        .beat_i     (beat_i),
        .tx_empty_i (tx_empty_i),
        .rx_full_i  (rx_full_i),
        .cfg_o      (cfg),
        .load_o     (load),
        .fire_o     (fire),
        .byte_end_o (byte_end),
        .busy_o     (busy_o),
        .shifting_o (sclk_en_o),
        .done_o     (done_o)
    );

    mlx_lane_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .srst_i     (srst_i),
        .lanes_i    (cfg.lanes),
        .load_i     (load),
        .load_val_i (cfg.tx_on ? tx_data_i : 8'h00),
        .fire_i     (fire),
        .dq_i       (dq_i),
        .dq_o       (dq_o),
        .rx_nxt_o   (rx_data_o)
    );

    assign tx_pop_o  = load && cfg.tx_on;
    assign rx_push_o = byte_end && cfg.rx_on;

    // R3
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pop_o |-> !tx_empty_i);

    // R5
    tx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !cfg.tx_on) |-> (dq_o == 4'b0000));

    // R2
    single_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.lanes == LANE_X1) |-> (dq_o[3:1] == 3'b000));

    // R6
    handshake_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_pop_o, rx_push_o}));

endmodule

// File: tb/sim_mlx_xfer_seq.sv
module sim_mlx_xfer_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0, srst_i = 1'b0, tx_en_i = 1'b0, rx_en_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] len_i = '0;
    logic        done_clr_i = 1'b0, beat_i = 1'b0, rx_full_i = 1'b0;
    logic        sclk_en_o, tx_pop_o, rx_push_o, busy_o, done_o;
    logic [3:0]  dq_o, dq_i, dq_fix = 4'b0;
    logic [7:0]  tx_data_i, rx_data_o;
    logic        tx_empty_i;
    logic        lb = 1'b0, slow = 1'b0, pop_pend = 1'b0;

    logic [7:0]  txq [512];
    logic [7:0]  rxq [512];
    logic [7:0]  obs [512];
    logic [8:0]  tx_rd = '0, tx_wr = '0;
    int          exp_lanes = 1;
    int          checks = 0, errors = 0;
    int          obs_n = 0, beats = 0, bitc = 0, pop_cnt = 0, push_cnt = 0, rx_n = 0;
    logic [7:0]  acc = '0;

    always #10 clk = ~clk;

    mlx_xfer_seq u0 (
        .clk(clk), .rst(rst), .en_i(en_i), .srst_i(srst_i), .mode_i(mode_i),
        .tx_en_i(tx_en_i), .rx_en_i(rx_en_i), .len_i(len_i), .done_clr_i(done_clr_i),
        .beat_i(beat_i), .sclk_en_o(sclk_en_o), .dq_o(dq_o), .dq_i(dq_i),
        .tx_data_i(tx_data_i), .tx_empty_i(tx_empty_i), .tx_pop_o(tx_pop_o),
        .rx_data_o(rx_data_o), .rx_full_i(rx_full_i), .rx_push_o(rx_push_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    assign tx_empty_i = (tx_rd == tx_wr);
    assign tx_data_i  = txq[tx_rd];
    assign dq_i = !lb ? dq_fix : (exp_lanes == 1) ? {2'b00, dq_o[0], 1'b0} : dq_o;

    always @(posedge clk) begin
        beat_i <= slow ? ~beat_i : 1'b1;
        if (pop_pend) tx_rd <= tx_rd + 9'd1;
    end

    always @(negedge clk) begin
        pop_pend = tx_pop_o;
        if (tx_pop_o) pop_cnt++;
        if (rx_push_o) begin rxq[rx_n] = rx_data_o; rx_n++; push_cnt++; end
        if (sclk_en_o && beat_i) begin
            beats++;
            if (exp_lanes == 1)      acc = {acc[6:0], dq_o[0]};
            else if (exp_lanes == 2) acc = {acc[5:0], dq_o[1:0]};
            else                     acc = {acc[3:0], dq_o};
            bitc += exp_lanes;
            if (bitc == 8) begin obs[obs_n] = acc; obs_n++; bitc = 0; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 29 + seed) & 8'hFF);
    endfunction

    task automatic prep(input int code, input int n, input bit te, input bit re,
                        input bit loop, input logic [3:0] fix, input bit fill, input int seed);
        @(negedge clk);
        exp_lanes = (code == 1) ? 2 : (code == 2) ? 4 : 1;
        obs_n = 0; beats = 0; bitc = 0; pop_cnt = 0; push_cnt = 0; rx_n = 0;
        for (int i = 0; i < n; i++) txq[9'(tx_rd + 9'(i))] = pat(i, seed);
        tx_wr = (te && fill) ? 9'(tx_rd + 9'(n)) : tx_rd;
        mode_i = 3'(code); tx_en_i = te; rx_en_i = re; len_i = 16'(n);
        lb = loop; dq_fix = fix;
    endtask

    task automatic kick(input string req, input bit expect_busy);
        en_i = 1'b1;
        @(negedge clk);
        en_i = 1'b0;
        len_i = '0;
        mode_i = (mode_i == 3'd2) ? 3'd0 : 3'd2;
        if (expect_busy) chk(req, "busy after start", busy_o, 1);
    endtask

    task automatic wait_done(input string req);
        int k = 0;
        while (!done_o && k < 5000) begin @(negedge clk); k++; end
        chk(req, "done reached", done_o, 1);
    endtask

    task automatic verify(input string req, input int n, input bit te, input bit re,
                          input bit loop, input logic [7:0] rx_fixed, input int seed);
        int bad_tx = 0, bad_rx = 0;
        for (int i = 0; i < n; i++) begin
            if (obs[i] != (te ? pat(i, seed) : 8'h00)) bad_tx++;
            if (re && rxq[i] != (loop ? (te ? pat(i, seed) : 8'h00) : rx_fixed)) bad_rx++;
        end
        chk(req, "beat count", beats, n * 8 / exp_lanes);
        chk(req, "line bytes mismatched", bad_tx, 0);
        chk(req, "pop count", pop_cnt, te ? n : 0);
        chk(req, "push count", push_cnt, re ? n : 0);
        if (re) chk(req, "received bytes mismatched", bad_rx, 0);
    endtask

    task automatic clear_done(input string req);
        repeat (4) @(negedge clk);
        chk(req, "done sticky", done_o, 1);
        done_clr_i = 1'b1;
        @(negedge clk);
        done_clr_i = 1'b0;
        chk(req, "done cleared", done_o, 0);
    endtask

    task automatic t_reset();
        chk("R8", "reset busy", busy_o, 0);
        chk("R8", "reset done", done_o, 0);
        chk("R8", "reset sclk_en", sclk_en_o, 0);
        chk("R8", "reset dq", dq_o, 0);
    endtask

    task automatic t_mode(input string req, input int code, input int n, input bit te,
                          input bit re, input bit loop, input logic [3:0] fix,
                          input logic [7:0] rx_fixed, input int seed);
        prep(code, n, te, re, loop, fix, 1'b1, seed);
        kick("R1", 1'b1);
        wait_done(req);
        verify(req, n, te, re, loop, rx_fixed, seed);
        clear_done("R7");
    endtask

    task automatic t_tx_stall();
        int hi = 0;
        prep(1, 2, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 11);
        kick("R3", 1'b1);
        repeat (12) begin @(negedge clk); if (sclk_en_o) hi++; end
        chk("R3", "clock ran while empty", hi, 0);
        chk("R3", "busy during stall", busy_o, 1);
        tx_wr = 9'(tx_rd + 9'd2);
        wait_done("R3");
        verify("R3", 2, 1'b1, 1'b0, 1'b0, 8'h00, 11);
        clear_done("R7");
    endtask

    task automatic t_rx_stall();
        int hi = 0;
        prep(2, 2, 1'b1, 1'b1, 1'b1, 4'b0, 1'b1, 3);
        rx_full_i = 1'b1;
        kick("R4", 1'b1);
        repeat (12) begin @(negedge clk); if (sclk_en_o) hi++; end
        chk("R4", "clock ran while full", hi, 0);
        chk("R4", "pops while full", pop_cnt, 0);
        rx_full_i = 1'b0;
        wait_done("R4");
        verify("R4", 2, 1'b1, 1'b1, 1'b1, 8'h00, 3);
        clear_done("R7");
    endtask

    task automatic t_abort();
        int pc;
        prep(0, 10, 1'b1, 1'b0, 1'b0, 4'b0, 1'b1, 7);
        kick("R8", 1'b1);
        repeat (20) @(negedge clk);
        srst_i = 1'b1;
        @(negedge clk);
        srst_i = 1'b0;
        chk("R8", "busy after abort", busy_o, 0);
        chk("R8", "sclk_en after abort", sclk_en_o, 0);
        chk("R8", "dq after abort", dq_o, 0);
        pc = pop_cnt;
        repeat (30) @(negedge clk);
        chk("R8", "pops after abort", pop_cnt, pc);
        chk("R8", "done after abort", done_o, 0);
        tx_wr = tx_rd;
        prep(0, 0, 1'b1, 1'b1, 1'b0, 4'b0, 1'b1, 0);
        kick("R9", 1'b0);
        chk("R9", "zero length done", done_o, 1);
        chk("R9", "zero length busy", busy_o, 0);
        chk("R9", "zero length pops", pop_cnt + push_cnt + beats, 0);
        srst_i = 1'b1;
        @(negedge clk);
        srst_i = 1'b0;
        chk("R8", "done cleared by soft reset", done_o, 0);
    endtask

    task automatic t_edge();
        prep(0, 1, 1'b1, 1'b0, 1'b0, 4'b0, 1'b1, 9);
        en_i = 1'b1;
        wait_done("R10");
        done_clr_i = 1'b1;
        @(negedge clk);
        done_clr_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10", "restart while held", busy_o, 0);
        chk("R10", "pops while held", pop_cnt, 1);
        en_i = 1'b0;
        prep(2, 3, 1'b1, 1'b0, 1'b0, 4'b0, 1'b1, 21);
        kick("R10", 1'b1);
        @(negedge clk);
        en_i = 1'b1;
        @(negedge clk);
        en_i = 1'b0;
        wait_done("R10");
        repeat (10) @(negedge clk);
        chk("R10", "busy after ignored edge", busy_o, 0);
        verify("R10", 3, 1'b1, 1'b0, 1'b0, 8'h00, 21);
        clear_done("R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode("R2", 0, 4, 1'b1, 1'b1, 1'b1, 4'b0, 8'h00, 1);
        t_mode("R2", 1, 4, 1'b1, 1'b1, 1'b1, 4'b0, 8'h00, 2);
        t_mode("R2", 2, 4, 1'b1, 1'b1, 1'b1, 4'b0, 8'h00, 5);
        t_mode("R2", 5, 2, 1'b1, 1'b0, 1'b0, 4'b0, 8'h00, 8);
        t_mode("R5", 0, 3, 1'b0, 1'b1, 1'b0, 4'b0101, 8'h00, 0);
        t_mode("R5", 1, 3, 1'b0, 1'b1, 1'b0, 4'b1010, 8'hAA, 0);
        t_mode("R6", 2, 3, 1'b1, 1'b0, 1'b1, 4'b0, 8'h00, 4);
        slow = 1'b1;
        t_mode("R6", 0, 2, 1'b0, 1'b1, 1'b0, 4'b0010, 8'hFF, 0);
        slow = 1'b0;
        t_tx_stall();
        t_rx_stall();
        t_abort();
        t_edge();
        t_mode("R11", 2, 300, 1'b1, 1'b1, 1'b1, 4'b0, 8'h00, 13);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule